// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic datapath of a small 8-bit accumulator processor. In one cycle it takes the current accumulator, a second operand, a 5-bit operation code and the current flag byte. From these it works out a new accumulator value and a new flag byte, using the carry and half-carry rules that software written for this class of processor depends on. When the write strobe is high, both results are stored on the rising clock edge and show on the registered outputs. When the strobe is low, the stored values are held.

The surrounding core handles instruction fetch, decoding, register selection and memory access. Those functions are not part of this block. The core passes its flag register back in on `flags_i` and feeds the registered outputs into its register file. Flag bits 5, 3 and 1 are not defined by any operation, so the block copies them from `flags_i` unchanged.

Top module: `acc_flag_alu`

## Requirements
- R1: Flag byte layout: sign = bit 7, zero = bit 6, half-carry = bit 4, parity = bit 2, carry = bit 0. Every operation that sets the result flags does so from its 8-bit result as follows: sign = result bit 7, zero = (result == 0), parity = 1 when the count of set bits is even. Bits 5, 3 and 1 of the new flags always equal `flags_i`.
- R2: Opcode 0 adds; opcode 1 adds plus the carry-in (`flags_i` bit 0). Carry = the ninth bit of the sum. Half-carry = 1 when the low-nibble sum plus carry-in is greater than 15.
- R3: Opcode 2 subtracts; opcode 3 subtracts the operand and the carry-in. Carry = 1 when the operand plus the carry-in is larger than the accumulator (a borrow). Half-carry = 1 when there is no borrow out of the low nibble: operand nibble <= accumulator nibble without carry-in, operand nibble < accumulator nibble with carry-in.
- R4: Opcode 4 (compare) sets all flags as opcode 2 does, but the accumulator keeps its input value.
- R5: Opcodes 5, 6 and 7 produce AND, OR and XOR. All three clear carry. AND sets half-carry to bit 3 of (accumulator OR operand). OR and XOR clear half-carry.
- R6: Opcodes 8 and 9 rotate left and right. The bit shifted out goes both into carry and into the vacated bit. Opcodes 10 and 11 rotate left and right through carry: the old carry fills the vacated bit. Rotates change no flag except carry.
- R7: Opcodes 12 and 13 increment and decrement. They update sign, zero, parity and half-carry, and leave carry unchanged. Half-carry is 1 on increment when the low nibble was 0xF, and 1 on decrement when the low nibble was not zero.
- R8: Opcode 14 (decimal adjust) works in two steps. Step 1: if the low nibble is greater than 9 or half-carry is set, add 0x06 and set half-carry to the overflow of the low nibble. Step 2: if the high nibble of the step-1 value is greater than 9 or carry is set, add 0x60. Carry is set when either step overflows past 8 bits, and it is never cleared.
- R9: Opcode 15 complements the accumulator and leaves the flags unchanged. Opcode 16 inverts only flag bit 0. Opcode 17 forces flag bit 0 to 1.
- R10: The new values are stored on a rising clock edge only when `we_i` is high; otherwise the outputs hold. Opcodes 18 to 31 store `acc_i` and `flags_i` unchanged.
- R11: While reset is active, and until the first write after reset, `acc_o` reads ACC_RST and `flg_o` reads FLG_RST. Reset is asserted asynchronously and released two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Commit strobe for accumulator and flags |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Current accumulator |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 8 | Current flag byte |
| acc_o | output | 8 | Registered accumulator result |
| flg_o | output | 8 | Registered flag byte |

## Verification
The bench builds the block with ACC_RST = 0x00 and FLG_RST = 0x02. It checks the reset state and confirms that a non-zero flag reset value is honoured bit by bit. Because `flags_i` is random, every operation sees both carry-in values and both half-carry inputs. This covers the decimal-adjust branches and the carry-dependent half-carry rules of add-with-carry and subtract-with-borrow.

// File: rtl/accalu_pkg.sv
package accalu_pkg;
  localparam int DW  = 8;
  localparam int NW  = DW / 2;
  localparam int OPW = 5;

  localparam int FB_S  = 7;
  localparam int FB_Z  = 6;
  localparam int FB_AC = 4;
  localparam int FB_P  = 2;
  localparam int FB_C  = 0;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
    OP_RLC = 5'd8,  OP_RRC = 5'd9,  OP_RAL = 5'd10, OP_RAR = 5'd11,
    OP_INC = 5'd12, OP_DEC = 5'd13, OP_DAA = 5'd14, OP_CMA = 5'd15,
    OP_CMC = 5'd16, OP_STC = 5'd17
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import accalu_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic           cin,
  output logic [DW-1:0]  res,
  output logic           cy,
  output logic           hc
);
  logic          sub;
  logic          ci;
  logic [DW-1:0] bb;
  logic [DW:0]   full;
  logic [NW:0]   lo;

  always_comb begin
    sub = 1'b0;
    ci  = 1'b0;
    bb  = b;
    case (op)
      OP_ADC:         ci = cin;
      OP_SUB, OP_CMP: sub = 1'b1;
      OP_SBB: begin sub = 1'b1; ci = cin; end
      OP_INC:         bb = {{(DW-1){1'b0}}, 1'b1};
      OP_DEC: begin sub = 1'b1; bb = {{(DW-1){1'b0}}, 1'b1}; end
      default: ;
    endcase
    if (sub) begin
      full = {1'b0, a} - {1'b0, bb} - {{DW{1'b0}}, ci};
      lo   = {1'b0, a[NW-1:0]} - {1'b0, bb[NW-1:0]} - {{NW{1'b0}}, ci};
      hc   = ~lo[NW];
    end else begin
      full = {1'b0, a} + {1'b0, bb} + {{DW{1'b0}}, ci};
      lo   = {1'b0, a[NW-1:0]} + {1'b0, bb[NW-1:0]} + {{NW{1'b0}}, ci};
      hc   = lo[NW];
    end
    res = full[DW-1:0];
    cy  = full[DW];
  end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import accalu_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic           cin,
  output logic [DW-1:0]  res,
  output logic           cy,
  output logic           hc
);
  logic [DW-1:0] either;
  assign either = a | b;

  always_comb begin
    res = a;
    cy  = cin;
    hc  = 1'b0;
    case (op)
      OP_AND: begin res = a & b; cy = 1'b0; hc = either[3]; end
      OP_OR:  begin res = either; cy = 1'b0; end
      OP_XOR: begin res = a ^ b;  cy = 1'b0; end
      OP_RLC: begin res = {a[DW-2:0], a[DW-1]}; cy = a[DW-1]; end
      OP_RRC: begin res = {a[0], a[DW-1:1]};    cy = a[0]; end
      OP_RAL: begin res = {a[DW-2:0], cin};     cy = a[DW-1]; end
      OP_RAR: begin res = {cin, a[DW-1:1]};     cy = a[0]; end
      OP_CMA: res = ~a;
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_decadj.sv
module alu_decadj
  import accalu_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic          cin,
  input  logic          hcin,
  output logic [DW-1:0] res,
  output logic          cy,
  output logic          hc
);
  logic [DW:0] t1;
  logic [DW:0] t2;
  logic [NW:0] lo_adj;

  always_comb begin
    t1     = {1'b0, a};
    cy     = cin;
    hc     = hcin;
    lo_adj = {1'b0, a[NW-1:0]} + (NW+1)'(6);
    if ((a[NW-1:0] > 4'd9) || hcin) begin
      hc = lo_adj[NW];
      t1 = t1 + (DW+1)'(6);
      cy = cy | t1[DW];
    end
    t2 = t1;
    if ((t1[DW-1:NW] > 4'd9) || cy) begin
      t2 = t1 + (DW+1)'(9'h060);
      cy = cy | t2[DW];
    end
    res = t2[DW-1:0];
  end
endmodule

// File: rtl/acc_flag_alu.sv
module acc_flag_alu
  import accalu_pkg::*;
#(
  parameter logic [7:0] ACC_RST = 8'h00,
  parameter logic [7:0] FLG_RST = 8'h02
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic [4:0] op_i,
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic [7:0] flags_i,
  output logic [7:0] acc_o,
  output logic [7:0] flg_o
);
  logic [1:0]    rst_sync;
  logic          rst_q_n;
  logic [DW-1:0] as_res, bo_res, da_res;
  logic          as_cy, as_hc, bo_cy, bo_hc, da_cy, da_hc;
  logic [DW-1:0] acc_d, acc_q, zsrc;
  logic [DW-1:0] flg_d, flg_q;
  logic          szp_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  alu_addsub u_as (
    .op(op_i), .a(acc_i), .b(opnd_i), .cin(flags_i[FB_C]),
    .res(as_res), .cy(as_cy), .hc(as_hc)
  );

  alu_bitops u_bo (
    .op(op_i), .a(acc_i), .b(opnd_i), .cin(flags_i[FB_C]),
    .res(bo_res), .cy(bo_cy), .hc(bo_hc)
  );

  alu_decadj u_da (
    .a(acc_i), .cin(flags_i[FB_C]), .hcin(flags_i[FB_AC]),
    .res(da_res), .cy(da_cy), .hc(da_hc)
  );

  always_comb begin
    acc_d  = acc_i;
    flg_d  = flags_i;
    zsrc   = as_res;
    szp_en = 1'b0;
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        acc_d = as_res; szp_en = 1'b1;
        flg_d[FB_C] = as_cy; flg_d[FB_AC] = as_hc;
      end
      OP_CMP: begin
        szp_en = 1'b1;
        flg_d[FB_C] = as_cy; flg_d[FB_AC] = as_hc;
      end
      OP_INC, OP_DEC: begin
        acc_d = as_res; szp_en = 1'b1;
        flg_d[FB_AC] = as_hc;
      end
      OP_AND, OP_OR, OP_XOR: begin
        acc_d = bo_res; zsrc = bo_res; szp_en = 1'b1;
        flg_d[FB_C] = bo_cy; flg_d[FB_AC] = bo_hc;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        acc_d = bo_res; flg_d[FB_C] = bo_cy;
      end
      OP_CMA: acc_d = bo_res;
      OP_DAA: begin
        acc_d = da_res; zsrc = da_res; szp_en = 1'b1;
        flg_d[FB_C] = da_cy; flg_d[FB_AC] = da_hc;
      end
      OP_CMC: flg_d[FB_C] = ~flags_i[FB_C];
      OP_STC: flg_d[FB_C] = 1'b1;
      default: ;
    endcase
    if (szp_en) begin
      flg_d[FB_S] = zsrc[DW-1];
      flg_d[FB_Z] = (zsrc == '0);
      flg_d[FB_P] = ~^zsrc;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      acc_q <= ACC_RST;
      flg_q <= FLG_RST;
    end else if (we_i) begin
      acc_q <= acc_d;
      flg_q <= flg_d;
    end
  end

  assign acc_o = acc_q;
  assign flg_o = flg_q;
endmodule

// File: rtl/acc_flag_alu_chk.sv
module acc_flag_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       we_i,
  input logic [4:0] op_i,
  input logic [7:0] acc_i,
  input logic [7:0] flags_i,
  input logic [7:0] acc_o,
  input logic [7:0] flg_o
);
  logic sets_res;
  assign sets_res = we_i && ((op_i <= 5'd3) || (op_i >= 5'd5 && op_i <= 5'd7) ||
                             op_i == 5'd12 || op_i == 5'd13 || op_i == 5'd14);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> ($stable(acc_o) && $stable(flg_o)));

  assert_spare_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (flg_o[5] == $past(flags_i[5]) && flg_o[3] == $past(flags_i[3]) &&
              flg_o[1] == $past(flags_i[1])));

  assert_szp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sets_res |=> (flg_o[6] == (acc_o == 8'h00) && flg_o[7] == acc_o[7] &&
                  flg_o[2] == ~^acc_o));

  assert_cmp_keeps_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && op_i == 5'd4) |=> acc_o == $past(acc_i));

  assert_logic_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (op_i == 5'd6 || op_i == 5'd7)) |=> (flg_o[0] == 1'b0 && flg_o[4] == 1'b0));

  assert_rot_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && op_i >= 5'd8 && op_i <= 5'd11) |=> flg_o[7:1] == $past(flags_i[7:1]));

  assert_incdec_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (op_i == 5'd12 || op_i == 5'd13)) |=> flg_o[0] == $past(flags_i[0]));

  assert_daa_carry_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && op_i == 5'd14 && flags_i[0]) |=> flg_o[0]);

  assert_cma_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && op_i == 5'd15) |=> (flg_o == $past(flags_i) && acc_o == ~$past(acc_i)));
endmodule

bind acc_flag_alu acc_flag_alu_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .we_i(we_i), .op_i(op_i), .acc_i(acc_i),
  .flags_i(flags_i), .acc_o(acc_o), .flg_o(flg_o)
);

// File: tb/sim_acc_flag_alu.sv
`timescale 1ns/1ps
module sim_acc_flag_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we_i = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0, flags_i = '0;
  logic [7:0] acc_o, flg_o;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  acc_flag_alu #(.ACC_RST(8'h00), .FLG_RST(8'h02)) u0 (
    .clk(clk), .rst_n(rst_n), .we_i(we_i), .op_i(op_i), .acc_i(acc_i),
    .opnd_i(opnd_i), .flags_i(flags_i), .acc_o(acc_o), .flg_o(flg_o)
  );

  function automatic logic [15:0] model(int op, int a, int b, logic [7:0] f);
    int r = a;
    int cy = int'(f[0]);
    int t;
    logic [7:0] nf = f;
    logic [7:0] rb;
    bit szp = 1'b0;
    bit keep = 1'b0;
    case (op)
      0: begin r = a + b; nf[0] = (r > 255); nf[4] = ((a % 16) + (b % 16)) > 15; szp = 1; end
      1: begin r = a + b + cy; nf[0] = (r > 255); nf[4] = ((a % 16) + (b % 16) + cy) > 15; szp = 1; end
      2, 4: begin
        r = (a - b + 256) % 256; nf[0] = (b > a); nf[4] = (b % 16) <= (a % 16); szp = 1;
        keep = (op == 4);
      end
      3: begin
        r = (a - b - cy + 512) % 256;
        nf[0] = (r >= a) && (b != 0 || cy != 0);
        nf[4] = (cy != 0) ? ((b % 16) < (a % 16)) : ((b % 16) <= (a % 16));
        szp = 1;
      end
      5: begin r = a & b; nf[0] = 0; nf[4] = ((a | b) & 8) != 0; szp = 1; end
      6: begin r = a | b; nf[0] = 0; nf[4] = 0; szp = 1; end
      7: begin r = a ^ b; nf[0] = 0; nf[4] = 0; szp = 1; end
      8: begin nf[0] = a >= 128; r = ((a * 2) % 256) + (a / 128); end
      9: begin nf[0] = a[0]; r = (a / 2) + (a % 2) * 128; end
      10: begin nf[0] = a >= 128; r = ((a * 2) % 256) + cy; end
      11: begin nf[0] = a[0]; r = (a / 2) + cy * 128; end
      12: begin r = (a + 1) % 256; nf[4] = (a % 16) == 15; szp = 1; end
      13: begin r = (a + 255) % 256; nf[4] = (a % 16) != 0; szp = 1; end
      14: begin
        t = a;
        if ((t % 16) > 9 || f[4]) begin nf[4] = ((t % 16) + 6) > 15; t = t + 6; if (t > 255) cy = 1; end
        if (((t / 16) % 16) > 9 || cy != 0) begin t = t + 96; if (t > 255) cy = 1; end
        nf[0] = cy[0]; r = t % 256; szp = 1;
      end
      15: r = 255 - a;
      16: nf[0] = ~f[0];
      17: nf[0] = 1'b1;
      default: r = a;
    endcase
    rb = r[7:0];
    if (szp) begin
      nf[7] = rb[7]; nf[6] = (rb == 0); nf[2] = ($countones(rb) % 2) == 0;
    end
    if (keep) rb = a[7:0];
    return {rb, nf};
  endfunction

  function automatic string tag(int op);
    case (op)
      0, 1: return "R2";
      2, 3: return "R3";
      4: return "R4";
      5, 6, 7: return "R5";
      8, 9, 10, 11: return "R6";
      12, 13: return "R7";
      14: return "R8";
      15, 16, 17: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: acc/flags actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a negative edge; returns at the next negative edge after the commit.
  task automatic run_op(int op, int a, int b, logic [7:0] f);
    logic [15:0] exp;
    op_i = op[4:0]; acc_i = a[7:0]; opnd_i = b[7:0]; flags_i = f; we_i = 1'b1;
    exp = model(op, a, b, f);
    @(negedge clk);
    check({tag(op), "+R1"}, {acc_o, flg_o}, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    check("R11", {acc_o, flg_o}, 16'h0002);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11", {acc_o, flg_o}, 16'h0002);

    // directed corners
    run_op(0, 8'hFF, 8'h01, 8'h00);  // R2: wraps to zero, flags 0x55
    check("R2", {acc_o, flg_o}, 16'h0055);
    run_op(1, 8'h0F, 8'h00, 8'h01);  // R2 half-carry with carry-in
    run_op(2, 8'h05, 8'h05, 8'h00);  // R3 equal
    run_op(3, 8'h05, 8'hFF, 8'h01);  // R3 borrow wrap
    run_op(3, 8'h00, 8'h00, 8'h01);  // R3 borrow from carry only
    run_op(4, 8'h10, 8'h20, 8'hFF);  // R4
    run_op(5, 8'h08, 8'h00, 8'h00);  // R5 half-carry from OR bit 3
    run_op(8, 8'h81, 8'h00, 8'h00);  // R6
    run_op(11, 8'h01, 8'h00, 8'h01); // R6
    run_op(12, 8'hFF, 8'h00, 8'h01); // R7 carry kept
    run_op(13, 8'h00, 8'h00, 8'h00); // R7
    run_op(14, 8'h9B, 8'h00, 8'h00); // R8 both steps
    check("R8", {acc_o, flg_o}, 16'h0111);
    run_op(14, 8'h00, 8'h00, 8'h01); // R8 carry stays set
    run_op(14, 8'hFA, 8'h00, 8'h00); // R8 overflow in first step
    run_op(15, 8'h5A, 8'h00, 8'hD7); // R9
    run_op(16, 8'h00, 8'h00, 8'hFF); // R9
    run_op(17, 8'h00, 8'h00, 8'h00); // R9
    run_op(20, 8'h33, 8'h44, 8'hAA); // R10 unused code

    // R10: strobe low holds outputs
    held = {acc_o, flg_o};
    we_i = 1'b0; op_i = 5'd0; acc_i = 8'h77; opnd_i = 8'h11; flags_i = 8'h55;
    repeat (2) @(negedge clk);
    check("R10", {acc_o, flg_o}, held);

    process::self().srandom(32'd1234);
    for (int i = 0; i < 30000; i++) begin
      int op;
      op = ($urandom % 16 == 0) ? int'($urandom % 32) : int'($urandom % 18);
      run_op(op, int'($urandom % 256), int'($urandom % 256), 8'($urandom));
    end

    we_i = 1'b0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule